// File: doc/BRIEF.md
# NAND Page ECC Parity Generator

This block computes Hamming-style parity over NAND page data while the bytes stream past during a page transfer. Each 256-byte section produces two 11-bit words. The first word, P, holds parities over the groups of bit positions and byte positions whose index bit is 1. The second word, P', holds the complementary parities over the groups whose index bit is 0. A correction routine later compares these words against stored copies.

Software pulses a clear strobe before each page. It then chooses a page size of 256 or 512 bytes and feeds the bytes with a valid qualifier. In 512-byte mode the two halves are covered independently, in two register pairs. A done flag rises once the configured number of bytes has been absorbed. To report a section, software packs it as the 22-bit value {P', P} and sends it as three bytes, least significant byte first.

Top module: `nand_ecc_gen`

## Requirements
- R1: While rst_ni is low, all four ECC outputs read 0, and done_o and clr_busy_o read 0.
- R2: A clear_i high at a clock edge takes precedence over valid_i. In the next cycle every ECC output and the byte counter are 0, done_o is 0, and clr_busy_o is 1 for exactly that one cycle.
- R3: A byte presented while clr_busy_o is 1 is not absorbed. It changes no ECC output and does not advance the byte count.
- R4: Bit k of P (bits 2:0 of ecc0_o/ecc2_o) is the XOR of every data bit whose bit position (0 to 7) has bit k set. Bit k of P' (ecc1_o/ecc3_o) covers the bit positions with bit k clear.
- R5: Bit 3+j of P is the XOR of all data bits of the section's bytes whose in-section byte index (0 to 255) has bit j set. Bit 3+j of P' covers the indices with bit j clear.
- R6: With page_512_i = 1, accepted bytes 0 to 255 update ecc0_o/ecc1_o. Bytes 256 to 511 update ecc2_o/ecc3_o, and their in-section index restarts at 0.
- R7: With page_512_i = 0, only ecc0_o/ecc1_o change, and ecc2_o/ecc3_o stay 0.
- R8: An accepted byte's contribution is visible on the ECC outputs in the cycle right after it is accepted.
- R9: done_o rises in the cycle after the last byte of the configured page (the 256th or the 512th accepted byte). It stays high until the next clear_i.
- R10: Bytes presented while done_o is 1 are ignored, and every ECC output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clear_i | input | 1 | Synchronous clear strobe, issued before each page |
| page_512_i | input | 1 | 1: 512-byte page, 0: 256-byte page |
| valid_i | input | 1 | data_i carries a byte this cycle |
| data_i | input | 8 | Page data byte |
| ecc0_o | output | 11 | P of section 0 |
| ecc1_o | output | 11 | P' of section 0 |
| ecc2_o | output | 11 | P of section 1 |
| ecc3_o | output | 11 | P' of section 1 |
| done_o | output | 1 | Configured page fully absorbed |
| clr_busy_o | output | 1 | Clear in progress; input bytes ignored |

## Verification
A single byte with one bit set at a known index checks the column and row groupings directly. A design that swapped P and P', or indexed rows by the absolute page offset, would give other words. A 512-byte page whose halves differ exposes a design that mixes the sections or fails to restart the index at byte 256. Bytes driven during the busy cycle and after done catch a design that absorbs them, since the words change or done moves. An all-0xFF page must come back as zero in every word. Idle gaps in valid_i test that only qualified bytes advance the count.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  localparam int unsigned BYTE_W    = 8;
  localparam int unsigned SECT_LOG  = 8;
  localparam int unsigned NUM_SECT  = 2;
  localparam int unsigned BIT_LOG   = $clog2(BYTE_W);
  localparam int unsigned PAR_W     = BIT_LOG + SECT_LOG;
  localparam int unsigned SEC_SEL_W = $clog2(NUM_SECT);
  localparam int unsigned CNT_W     = SECT_LOG + SEC_SEL_W;

  typedef logic [PAR_W-1:0] par_t;
  typedef struct packed {
    par_t p;
    par_t pn;
  } par_pair_t;
endpackage

// File: rtl/ecc_byte_terms.sv
module ecc_byte_terms
  import nand_ecc_pkg::*;
(
  input  logic [BYTE_W-1:0]   data_i,
  input  logic [SECT_LOG-1:0] idx_i,
  output par_pair_t           term_o
);
  logic byte_par;
  assign byte_par = ^data_i;

  // column groups: bit positions selected by one bit of their own index
  for (genvar k = 0; k < BIT_LOG; k++) begin : g_col
    logic [BYTE_W-1:0] sel_mask;
    for (genvar b = 0; b < BYTE_W; b++) begin : g_m
      assign sel_mask[b] = ((b >> k) & 1) != 0;
    end
    assign term_o.p[k]  = ^(data_i & sel_mask);
    assign term_o.pn[k] = ^(data_i & ~sel_mask);
  end

  // row groups: whole-byte parity steered by the byte index
  for (genvar j = 0; j < SECT_LOG; j++) begin : g_row
    assign term_o.p[BIT_LOG+j]  = byte_par &  idx_i[j];
    assign term_o.pn[BIT_LOG+j] = byte_par & ~idx_i[j];
  end
endmodule

// File: rtl/ecc_section_acc.sv
module ecc_section_acc
  import nand_ecc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      clr_i,
  input  logic      en_i,
  input  par_pair_t term_i,
  output par_pair_t acc_o
);
  par_pair_t acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else if (en_i)  acc_q <= acc_q ^ term_i;
  end

  assign acc_o = acc_q;

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !en_i) |=> $stable(acc_q)); // R10
  AST_ACC_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (acc_q == '0)); // R2
endmodule

// File: rtl/ecc_byte_ctrl.sv
module ecc_byte_ctrl
  import nand_ecc_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 page_512_i,
  input  logic                 valid_i,
  output logic                 accept_o,
  output logic [SEC_SEL_W-1:0] sect_o,
  output logic [SECT_LOG-1:0]  idx_o,
  output logic                 done_o,
  output logic                 busy_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             done_q, busy_q, last_byte;

  assign accept_o  = valid_i && !clear_i && !busy_q && !done_q;
  assign idx_o     = cnt_q[SECT_LOG-1:0];
  assign sect_o    = page_512_i ? cnt_q[CNT_W-1:SECT_LOG] : '0;
  assign last_byte = page_512_i ? (&cnt_q) : (&cnt_q[SECT_LOG-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      busy_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
      busy_q <= 1'b1;
    end else begin
      busy_q <= 1'b0;
      if (accept_o) begin
        cnt_q <= cnt_q + 1'b1;
        if (last_byte) done_q <= 1'b1;
      end
    end
  end

  assign done_o = done_q;
  assign busy_o = busy_q;

  AST_BUSY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !clear_i) |=> !busy_q); // R2
  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_q && !clear_i) |=> done_q); // R9
  AST_NO_COUNT_WHEN_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((busy_q || done_q) && !clear_i) |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/nand_ecc_gen.sv
module nand_ecc_gen
  import nand_ecc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              page_512_i,
  input  logic              valid_i,
  input  logic [BYTE_W-1:0] data_i,
  output logic [PAR_W-1:0]  ecc0_o,
  output logic [PAR_W-1:0]  ecc1_o,
  output logic [PAR_W-1:0]  ecc2_o,
  output logic [PAR_W-1:0]  ecc3_o,
  output logic              done_o,
  output logic              clr_busy_o
);
  logic                 accept;
  logic [SEC_SEL_W-1:0] sect;
  logic [SECT_LOG-1:0]  idx;
  par_pair_t            term;
  par_pair_t            acc [NUM_SECT];

  ecc_byte_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (clear_i),
    .page_512_i (page_512_i),
    .valid_i    (valid_i),
    .accept_o   (accept),
    .sect_o     (sect),
    .idx_o      (idx),
    .done_o     (done_o),
    .busy_o     (clr_busy_o)
  );

  ecc_byte_terms u_terms (
    .data_i (data_i),
    .idx_i  (idx),
    .term_o (term)
  );

  for (genvar s = 0; s < NUM_SECT; s++) begin : g_sect
    ecc_section_acc u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clear_i),
      .en_i   (accept && (sect == s)),
      .term_i (term),
      .acc_o  (acc[s])
    );
  end

  assign ecc0_o = acc[0].p;
  assign ecc1_o = acc[0].pn;
  assign ecc2_o = acc[1].p;
  assign ecc3_o = acc[1].pn;

  AST_CLEAR_ZEROES_OUTPUTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (ecc0_o == '0 && ecc1_o == '0 && ecc2_o == '0 && ecc3_o == '0
                 && !done_o && clr_busy_o)); // R2
  AST_FROZEN_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> ($stable(ecc0_o) && $stable(ecc1_o)
                              && $stable(ecc2_o) && $stable(ecc3_o))); // R10
  AST_UPPER_UNTOUCHED_256: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!page_512_i && !clear_i) |=> ($stable(ecc2_o) && $stable(ecc3_o))); // R7
  AST_BUSY_IGNORES_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_busy_o && !clear_i) |=> ($stable(ecc0_o) && $stable(ecc1_o))); // R3
endmodule

// File: tb/nand_ecc_gen_tb.sv
module nand_ecc_gen_tb;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic clear_i = 1'b0, page_512_i = 1'b0, valid_i = 1'b0;
  logic [7:0] data_i = 8'h00;
  logic [10:0] ecc0_o, ecc1_o, ecc2_o, ecc3_o;
  logic done_o, clr_busy_o;

  int total = 0, bad = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  nand_ecc_gen u_dut (.*);

  // behavioural reference
  int m_p[2], m_pn[2];
  int m_cnt;
  bit m_done, m_busy;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_p = '{0, 0}; m_pn = '{0, 0}; m_cnt = 0; m_done = 0; m_busy = 0;
    end else if (clear_i) begin
      m_p = '{0, 0}; m_pn = '{0, 0}; m_cnt = 0; m_done = 0; m_busy = 1;
    end else begin
      if (valid_i && !m_busy && !m_done) begin
        int sec, a;
        sec = page_512_i ? m_cnt / 256 : 0;
        a   = m_cnt % 256;
        for (int b = 0; b < 8; b++) begin
          if (data_i[b]) begin
            for (int k = 0; k < 3; k++)
              if ((b >> k) & 1) m_p[sec] ^= (1 << k); else m_pn[sec] ^= (1 << k);
            for (int j = 0; j < 8; j++)
              if ((a >> j) & 1) m_p[sec] ^= (1 << (3 + j)); else m_pn[sec] ^= (1 << (3 + j));
          end
        end
        m_cnt++;
        if (m_cnt == (page_512_i ? 512 : 256)) m_done = 1;
      end
      m_busy = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk_i) if (rst_ni && !finished) begin
    check(ecc0_o == 11'(m_p[0]),  "R8 ecc0", ecc0_o, m_p[0]);
    check(ecc1_o == 11'(m_pn[0]), "R8 ecc1", ecc1_o, m_pn[0]);
    check(ecc2_o == 11'(m_p[1]),  "R6 ecc2", ecc2_o, m_p[1]);
    check(ecc3_o == 11'(m_pn[1]), "R6 ecc3", ecc3_o, m_pn[1]);
    check(done_o == m_done,       "R9 done", done_o, m_done);
    check(clr_busy_o == m_busy,   "R2 busy", clr_busy_o, m_busy);
  end

  task automatic send(input logic [7:0] d, input logic v);
    @(negedge clk_i);
    valid_i = v; data_i = d; clear_i = 0;
  endtask

  task automatic do_clear(input logic p512);
    @(negedge clk_i);
    clear_i = 1; valid_i = 0; page_512_i = p512;
    @(negedge clk_i);
    clear_i = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #200000;
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [10:0] held;
    #3;
    check(ecc0_o == 0 && ecc1_o == 0 && ecc2_o == 0 && ecc3_o == 0, "R1 ecc", ecc0_o, 0);
    check(!done_o && !clr_busy_o, "R1 flags", {done_o, clr_busy_o}, 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1;

    // single set bit: byte index 5, bit 3
    do_clear(0);
    check(clr_busy_o == 1, "R2 busy high", clr_busy_o, 1);
    for (int i = 0; i < 6; i++) send(i == 5 ? 8'h08 : 8'h00, 1);
    send(8'h00, 0);
    @(negedge clk_i);
    check(ecc0_o == 11'h02B, "R4 R5 P", ecc0_o, 11'h02B);
    check(ecc1_o == 11'h7D4, "R4 R5 Pn", ecc1_o, 11'h7D4);

    // byte during busy cycle ignored
    @(negedge clk_i); clear_i = 1; valid_i = 0;
    @(negedge clk_i); clear_i = 0; valid_i = 1; data_i = 8'h01;
    @(negedge clk_i); valid_i = 0;
    @(negedge clk_i);
    check(ecc0_o == 0 && ecc1_o == 0, "R3 busy byte", ecc1_o, 0);

    // 256-byte page with gaps
    do_clear(0);
    for (int i = 0; i < 256; i++) begin
      send(8'((i * 37 + 5) ^ (i >> 3)), 1);
      if (i % 17 == 3) send(8'hFF, 0);
    end
    send(8'h00, 0);
    check(done_o == 1, "R9 done 256", done_o, 1);
    check(ecc2_o == 0 && ecc3_o == 0, "R7 upper zero", ecc3_o, 0);
    held = ecc1_o;
    for (int i = 0; i < 8; i++) send(8'hA5, 1);
    send(8'h00, 0);
    check(ecc1_o == held && done_o, "R10 after done", ecc1_o, held);

    // 512-byte page, distinct halves
    do_clear(1);
    for (int i = 0; i < 512; i++) begin
      send(i < 256 ? 8'($urandom) : 8'(i * 11), 1);
      if (i == 510) check(done_o == 0, "R9 not early", done_o, 0);
    end
    send(8'h00, 0);
    check(done_o == 1, "R9 done 512", done_o, 1);

    // all-0xFF page yields zero words
    do_clear(1);
    for (int i = 0; i < 512; i++) send(8'hFF, 1);
    send(8'h00, 0);
    check(ecc0_o == 0 && ecc1_o == 0 && ecc2_o == 0 && ecc3_o == 0, "R6 all FF", ecc0_o, 0);

    // clear wins over valid
    @(negedge clk_i); clear_i = 1; valid_i = 1; data_i = 8'h80; page_512_i = 0;
    @(negedge clk_i); clear_i = 0; valid_i = 0;
    check(ecc0_o == 0 && !done_o, "R2 clear priority", ecc0_o, 0);
    repeat (2) @(negedge clk_i);
    finish_run();
  end
endmodule